// File: doc/BRIEF.md
# SPI flash command frame validator

This block is the slave-side command front end of a serial NOR flash. Serial clock, chip select and serial data arrive asynchronously. Each one passes through a two-flop synchronizer, and the block then detects their edges in the system clock domain. While chip select is low, the block shifts in one bit per rising serial clock edge, most significant bit first. It counts the bits and keeps the opcode byte, the 24-bit address and the first data byte in byte slots.

When chip select rises, a small state machine decides the frame. It moves from `ST_IDLE` to `ST_SHIFT` on the chip-select fall and from `ST_SHIFT` to `ST_JUDGE` on the chip-select rise. `ST_JUDGE` lasts one system clock. From there the machine returns to `ST_IDLE`, or goes straight to `ST_SHIFT` if a new frame has already begun.

In `ST_JUDGE`, every write-type frame produces exactly one execute strobe or one reject strobe. The decision uses the frame length and byte alignment, the write-enable latch, the busy flag and a block-protection decode. The captured opcode, address and data byte are driven out together with that strobe. Frames of any other kind leave the outputs untouched. The write-enable latch lives inside the block and is also an output.

Top module: `spi_cmd_gate`

## Requirements
- R1: Bits are taken MSB first. After a frame that gives a strobe, `cmd_op` holds the first byte of the frame, `cmd_addr` holds bytes 2 to 4 (byte 2 is bits 23:16), and `cmd_data` holds byte 5.
- R2: A write-type frame (opcodes 06h, 04h, 02h, 20h, D8h, C7h, 01h, B9h) whose bit count is not a multiple of 8 gets a reject strobe and no execute strobe.
- R3: The byte count, including the opcode, must be exactly 1 for 06h (set write enable), 04h (clear write enable), C7h (chip erase) and B9h (power down). It must be exactly 2 for 01h (status write), exactly 4 for 20h and D8h (sector and block erase), and at least 5 for 02h (page program). Any other count gives a reject.
- R4: The write-enable latch resets to 0. An executed 06h sets it. An executed 04h, 02h, 20h, D8h, C7h or 01h clears it. An executed B9h and any rejected frame leave it unchanged.
- R5: 02h, 20h, D8h, C7h and 01h are rejected while the write-enable latch is 0.
- R6: For 02h, 20h and D8h, the block is `cmd_addr[21:16]` (64 blocks of 64 KB). Let c = `bp_code[2:0]`: c=0 protects nothing, c=7 protects every block, and c from 1 to 6 protects 2^(c-1) blocks. With `bp_code[3]`=0 these are the highest blocks; with `bp_code[3]`=1 they are the lowest, starting at block 0. A frame that addresses a protected block is rejected.
- R7: C7h is rejected whenever `bp_code[2:0]` is not 0.
- R8: While `busy` is 1 at the decision, every write-type frame is rejected.
- R9: A frame with any other opcode, and a frame shorter than 8 bits, gives no strobe.
- R10: The strobes are one system clock wide and never both high. At most one strobe is given per frame.
- R11: `cmd_op`, `cmd_addr` and `cmd_data` change only in a cycle in which a strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock (asynchronous) |
| spi_cs_n | input | 1 | Chip select, active low (asynchronous) |
| spi_mosi | input | 1 | Serial data in (asynchronous) |
| bp_code | input | 4 | Block-protect code from the status register |
| busy | input | 1 | Internal write or erase cycle in progress |
| exec_stb | output | 1 | Frame accepted, one clock pulse |
| rej_stb | output | 1 | Frame refused, one clock pulse |
| cmd_op | output | 8 | Captured opcode |
| cmd_addr | output | 24 | Captured address |
| cmd_data | output | 8 | Captured first data byte |
| wel | output | 1 | Write-enable latch |

## Verification
On every cycle the assertions check the following:
- the strobes are exclusive and one clock wide;
- the captured fields are held between strobes;
- the latch changes only with an execute strobe;
- no accepted frame broke the latch, busy or chip-erase protection rules.

Only the bench scenarios can show the rest: that a given bit count or byte count is judged correctly, that the protect decode picks the right blocks for every code, and that the shifted bits land in the right byte slots. The bench sweeps bit counts for each opcode and sweeps all sixteen protect codes against a spread of blocks.

// File: rtl/spi_gate_pkg.sv
package spi_gate_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_SERA = 8'h20;
    localparam logic [7:0] OP_BERA = 8'hD8;
    localparam logic [7:0] OP_CERA = 8'hC7;
    localparam logic [7:0] OP_WRST = 8'h01;
    localparam logic [7:0] OP_SLEEP = 8'hB9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_JUDGE
    } gate_state_e;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_SETWE,
        CL_CLRWE,
        CL_PROG,
        CL_ERASE,
        CL_CHIP,
        CL_STAT,
        CL_SLEEP
    } cmd_class_e;

    function automatic cmd_class_e classify(input logic [7:0] op);
        cmd_class_e c;
        case (op)
            OP_WREN:  c = CL_SETWE;
            OP_WRDI:  c = CL_CLRWE;
            OP_PROG:  c = CL_PROG;
            OP_SERA:  c = CL_ERASE;
            OP_BERA:  c = CL_ERASE;
            OP_CERA:  c = CL_CHIP;
            OP_WRST:  c = CL_STAT;
            OP_SLEEP: c = CL_SLEEP;
            default:  c = CL_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= d_async[i];
                sync_q <= meta_q;
            end
        end
        assign d_sync[i] = sync_q;
    end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int CNT_W      = 12,
    parameter int ADDR_BYTES = 3,
    localparam int AW        = 8 * ADDR_BYTES,
    localparam int IDX_W     = CNT_W - 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             bit_stb,
    input  logic             mosi,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [7:0]       op_byte,
    output logic [AW-1:0]    addr,
    output logic [7:0]       data0
);
    logic [6:0]       sh_q;
    logic [7:0]       cur;
    logic [IDX_W-1:0] idx;

    assign cur = {sh_q, mosi};
    assign idx = bit_cnt[CNT_W-1:3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            bit_cnt <= '0;
            op_byte <= '0;
            addr    <= '0;
            data0   <= '0;
        end else if (frame_start) begin
            sh_q    <= '0;
            bit_cnt <= '0;
            op_byte <= '0;
            addr    <= '0;
            data0   <= '0;
        end else if (bit_stb) begin
            sh_q <= cur[6:0];
            if (bit_cnt != '1) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (bit_cnt[2:0] == 3'd7 && bit_cnt != '1) begin
                if (idx == '0) begin
                    op_byte <= cur;
                end
                for (int g = 0; g < ADDR_BYTES; g++) begin
                    if (idx == IDX_W'(g + 1)) begin
                        addr[AW-1-8*g -: 8] <= cur;
                    end
                end
                if (idx == IDX_W'(ADDR_BYTES + 1)) begin
                    data0 <= cur;
                end
            end
        end
    end
endmodule

// File: rtl/spi_prot_decode.sv
module spi_prot_decode #(
    parameter int BLK_W = 6
) (
    input  logic [3:0]       bp,
    input  logic [BLK_W-1:0] blk,
    output logic             blk_hit,
    output logic             any_prot
);
    localparam logic [BLK_W:0] ALL_BLK = {1'b1, {BLK_W{1'b0}}};

    logic [2:0]     code;
    logic [BLK_W:0] n_blk;
    logic [BLK_W:0] blk_x;

    assign code  = bp[2:0];
    assign blk_x = {1'b0, blk};

    always_comb begin
        if (code == 3'd0) begin
            n_blk = '0;
        end else if (code == 3'd7) begin
            n_blk = ALL_BLK;
        end else begin
            n_blk = {{BLK_W{1'b0}}, 1'b1} << (code - 3'd1);
        end
    end

    assign any_prot = (code != 3'd0);
    assign blk_hit  = bp[3] ? (blk_x < n_blk) : (blk_x >= (ALL_BLK - n_blk));
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_gate_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int ADDR_BYTES = 3,
    localparam int AW        = 8 * ADDR_BYTES,
    localparam int NB_W      = CNT_W - 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic [7:0]       op_byte,
    input  logic [AW-1:0]    addr,
    input  logic [7:0]       data0,
    input  logic             busy,
    input  logic             blk_hit,
    input  logic             any_prot,
    output logic             exec_stb,
    output logic             rej_stb,
    output logic [7:0]       op_o,
    output logic [AW-1:0]    addr_o,
    output logic [7:0]       data_o,
    output logic             wel_o
);
    gate_state_e st_q, st_d;
    cmd_class_e  cls;
    logic [NB_W-1:0] nbytes;
    logic aligned, len_ok, need_wel, prot_ok, go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cs_fall) st_d = ST_SHIFT;
            ST_SHIFT: if (cs_rise) st_d = ST_JUDGE;
            ST_JUDGE: st_d = cs_fall ? ST_SHIFT : ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    assign cls     = classify(op_byte);
    assign nbytes  = bit_cnt[CNT_W-1:3];
    assign aligned = (bit_cnt[2:0] == 3'd0);

    always_comb begin
        unique case (cls)
            CL_SETWE, CL_CLRWE, CL_CHIP, CL_SLEEP: len_ok = (nbytes == NB_W'(1));
            CL_STAT:  len_ok = (nbytes == NB_W'(2));
            CL_ERASE: len_ok = (nbytes == NB_W'(ADDR_BYTES + 1));
            CL_PROG:  len_ok = (nbytes >= NB_W'(ADDR_BYTES + 2));
            default:  len_ok = 1'b0;
        endcase
    end

    assign need_wel = (cls == CL_PROG) || (cls == CL_ERASE) || (cls == CL_CHIP) || (cls == CL_STAT);

    always_comb begin
        unique case (cls)
            CL_PROG, CL_ERASE: prot_ok = !blk_hit;
            CL_CHIP:           prot_ok = !any_prot;
            default:           prot_ok = 1'b1;
        endcase
    end

    assign go = aligned && len_ok && !busy && (!need_wel || wel_o) && prot_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_stb <= 1'b0;
            rej_stb  <= 1'b0;
            op_o     <= '0;
            addr_o   <= '0;
            data_o   <= '0;
            wel_o    <= 1'b0;
        end else begin
            exec_stb <= 1'b0;
            rej_stb  <= 1'b0;
            if (st_q == ST_JUDGE && cls != CL_NONE) begin
                exec_stb <= go;
                rej_stb  <= !go;
                op_o     <= op_byte;
                addr_o   <= addr;
                data_o   <= data0;
                if (go) begin
                    unique case (cls)
                        CL_SETWE: wel_o <= 1'b1;
                        CL_SLEEP: wel_o <= wel_o;
                        default:  wel_o <= 1'b0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/spi_cmd_gate.sv
module spi_cmd_gate #(
    parameter int CNT_W      = 12,
    parameter int ADDR_BYTES = 3,
    parameter int BLK_W      = 6,
    parameter int BLK_LSB    = 16,
    localparam int AW        = 8 * ADDR_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_cs_n,
    input  logic          spi_mosi,
    input  logic [3:0]    bp_code,
    input  logic          busy,
    output logic          exec_stb,
    output logic          rej_stb,
    output logic [7:0]    cmd_op,
    output logic [AW-1:0] cmd_addr,
    output logic [7:0]    cmd_data,
    output logic          wel
);
    logic [2:0] pins_s;
    logic sck_s, cs_s, mosi_s, sck_q, cs_q;
    logic cs_fall, cs_rise, bit_stb;
    logic [CNT_W-1:0] bit_cnt;
    logic [7:0] op_byte, data0;
    logic [AW-1:0] addr;
    logic blk_hit, any_prot;

    spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({spi_sck, spi_cs_n, spi_mosi}),
        .d_sync(pins_s)
    );
    assign {sck_s, cs_s, mosi_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_s;
        end
    end

    assign cs_fall = cs_q && !cs_s;
    assign cs_rise = !cs_q && cs_s;
    assign bit_stb = !sck_q && sck_s && !cs_s;

    spi_shifter #(.CNT_W(CNT_W), .ADDR_BYTES(ADDR_BYTES)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .frame_start(cs_fall), .bit_stb(bit_stb), .mosi(mosi_s),
        .bit_cnt(bit_cnt), .op_byte(op_byte), .addr(addr), .data0(data0)
    );

    spi_prot_decode #(.BLK_W(BLK_W)) u_prot (
        .bp(bp_code), .blk(addr[BLK_LSB +: BLK_W]),
        .blk_hit(blk_hit), .any_prot(any_prot)
    );

    spi_frame_fsm #(.CNT_W(CNT_W), .ADDR_BYTES(ADDR_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_fall(cs_fall), .cs_rise(cs_rise),
        .bit_cnt(bit_cnt), .op_byte(op_byte), .addr(addr), .data0(data0),
        .busy(busy), .blk_hit(blk_hit), .any_prot(any_prot),
        .exec_stb(exec_stb), .rej_stb(rej_stb),
        .op_o(cmd_op), .addr_o(cmd_addr), .data_o(cmd_data), .wel_o(wel)
    );
endmodule

// File: rtl/spi_cmd_gate_chk.sv
module spi_cmd_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  bp_code,
    input logic        busy,
    input logic        exec_stb,
    input logic        rej_stb,
    input logic [7:0]  cmd_op,
    input logic [23:0] cmd_addr,
    input logic [7:0]  cmd_data,
    input logic        wel
);
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_stb && rej_stb));

    p_exec_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |=> !exec_stb);

    p_rej_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rej_stb |=> !rej_stb);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_stb || rej_stb) |-> ($stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_data)));

    p_wel_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wel) |-> exec_stb);

    p_need_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && (cmd_op inside {8'h02, 8'h20, 8'hD8, 8'hC7, 8'h01})) |-> $past(wel));

    p_chip_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && cmd_op == 8'hC7) |-> ($past(bp_code[2:0]) == 3'd0));

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |-> !$past(busy));
endmodule

bind spi_cmd_gate spi_cmd_gate_chk u_chk (.*);

// File: tb/spi_cmd_gate_bench.sv
module spi_cmd_gate_bench;
    localparam int H = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic [3:0] bp = 4'd0;
    logic busy = 1'b0;
    logic exec_stb, rej_stb, wel;
    logic [7:0] cmd_op, cmd_data;
    logic [23:0] cmd_addr;

    int n_chk = 0, n_bad = 0, n_exec = 0, n_rej = 0;
    logic exp_wel = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_cmd_gate u_spi_cmd_gate (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .bp_code(bp), .busy(busy), .exec_stb(exec_stb), .rej_stb(rej_stb),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wel(wel)
    );

    always @(negedge clk) begin
        if (exec_stb) n_exec++;
        if (rej_stb)  n_rej++;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit is_prot(input logic [3:0] b, input int blk);
        int c = int'(b[2:0]);
        int n = (c == 0) ? 0 : (c == 7) ? 64 : (2 ** (c - 1));
        return b[3] ? (blk < n) : (blk >= 64 - n);
    endfunction

    function automatic int expect_kind(input logic [7:0] op, input int nbits, input logic w,
                                       input logic [3:0] b, input logic bsy, input logic [23:0] a);
        int nby;
        bit wr = op inside {8'h06, 8'h04, 8'h02, 8'h20, 8'hD8, 8'hC7, 8'h01, 8'hB9};
        if (nbits < 8 || !wr) return 0;
        if (nbits % 8 != 0) return 2;
        if (bsy) return 2;
        nby = nbits / 8;
        case (op)
            8'h02:        if (nby < 5) return 2;
            8'h20, 8'hD8: if (nby != 4) return 2;
            8'h01:        if (nby != 2) return 2;
            default:      if (nby != 1) return 2;
        endcase
        if ((op inside {8'h02, 8'h20, 8'hD8, 8'hC7, 8'h01}) && !w) return 2;
        if ((op inside {8'h02, 8'h20, 8'hD8}) && is_prot(b, int'(a[21:16]))) return 2;
        if (op == 8'hC7 && b[2:0] != 3'd0) return 2;
        return 1;
    endfunction

    task automatic send(input logic [63:0] v, input int nb);
        @(negedge clk) cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            mosi = v[63 - i];
            repeat (H) @(negedge clk);
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic run(input logic [63:0] v, input int nb, input string req);
        int e0 = n_exec;
        int r0 = n_rej;
        int ek = expect_kind(v[63:56], nb, exp_wel, bp, busy, v[55:32]);
        int got;
        send(v, nb);
        if (n_exec == e0 && n_rej == r0)          got = 0;
        else if (n_exec == e0 + 1 && n_rej == r0) got = 1;
        else if (n_rej == r0 + 1 && n_exec == e0) got = 2;
        else                                      got = 3;
        check(got == ek, {req, " strobe kind (R10 single pulse)"}, got, ek);
        if (ek == 1) begin
            if (v[63:56] == 8'h06)                   exp_wel = 1'b1;
            else if (v[63:56] != 8'hB9)              exp_wel = 1'b0;
        end
        check(wel == exp_wel, {req, " R4 latch"}, wel, exp_wel);
    endtask

    localparam logic [63:0] WREN = {8'h06, 56'h0};

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(exec_stb == 0 && rej_stb == 0, "R10 reset strobes", {exec_stb, rej_stb}, 0);
        check(wel == 0, "R4 reset latch", wel, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 and R9: set-enable frame with bit counts 0..16
        for (int nb = 0; nb <= 16; nb++) run(WREN, nb, "R2");
        run({8'h04, 56'h0}, 8, "R4");
        run({8'h20, 24'h000100, 32'h0}, 32, "R5");

        // R3: per-opcode byte counts, latch set before each frame
        for (int k = 1; k <= 8; k++) begin
            run(WREN, 8, "R3");
            run({8'h02, 24'h001000, 32'hA1B2C3D4}, 8 * k, "R3");
        end
        run(WREN, 8, "R3");
        run({8'h02, 24'h001000, 32'hA1B2C3D4}, 44, "R2");
        foreach (cmd_op[i]) begin end
        for (int k = 1; k <= 6; k++) begin
            run(WREN, 8, "R3");
            run({8'h20, 24'h002000, 32'h0}, 8 * k, "R3");
            run(WREN, 8, "R3");
            run({8'hD8, 24'h003000, 32'h0}, 8 * k, "R3");
        end
        for (int k = 1; k <= 3; k++) begin
            run(WREN, 8, "R3");
            run({8'h01, 8'h3C, 48'h0}, 8 * k, "R3");
            run(WREN, 8, "R3");
            run({8'hC7, 56'h0}, 8 * k, "R3");
            run({8'hB9, 56'h0}, 8 * k, "R3");
        end

        // R1: capture positions
        run(WREN, 8, "R1");
        run({8'h02, 24'h9A3C81, 8'hE7, 8'h55, 16'h0}, 48, "R1");
        check(cmd_op == 8'h02, "R1 opcode", cmd_op, 8'h02);
        check(cmd_addr == 24'h9A3C81, "R1 address", cmd_addr, 24'h9A3C81);
        check(cmd_data == 8'hE7, "R1 data", cmd_data, 8'hE7);

        // R9 and R11: foreign opcode leaves outputs alone
        run({8'h03, 24'h123456, 32'h0}, 32, "R9");
        check(cmd_op == 8'h02 && cmd_addr == 24'h9A3C81, "R11 hold", cmd_addr, 24'h9A3C81);

        // R6: protect codes against a spread of blocks
        for (int b = 0; b < 16; b++) begin
            bp = 4'(b);
            for (int j = 0; j < 16; j++) begin
                int blk = j * 4 + (j % 4);
                logic [23:0] a = {2'(j), 6'(blk), 16'h5A5A};
                run(WREN, 8, "R6");
                run({((j % 2) != 0) ? 8'hD8 : 8'h20, a, 32'h0}, 32, "R6");
            end
        end

        // R7: chip erase under every protect code
        for (int b = 0; b < 16; b++) begin
            bp = 4'(b);
            run(WREN, 8, "R7");
            run({8'hC7, 56'h0}, 8, "R7");
        end
        bp = 4'd0;

        // R8: busy refuses writes and keeps the latch
        run(WREN, 8, "R8");
        busy = 1'b1;
        run({8'h20, 24'h004000, 32'h0}, 32, "R8");
        run({8'h04, 56'h0}, 8, "R8");
        busy = 1'b0;
        run({8'h20, 24'h004000, 32'h0}, 32, "R8");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule